// File: doc/BRIEF.md
# Fixed-Length Recording Block Formatter

This block turns a stream of sensor samples into one fixed-length recording block of 24-bit words. During the capture phase it packs incoming samples bit by bit, MSB first, into a data store. The sample size follows a 4-bit format code. A close pulse ends capture. The block then emits every word of the block on a valid/ready word stream: an eight-word session header, a five-word channel header, the completed data words, and all-ones fill up to the fixed length.

The session header carries a split 29-bit sync pattern, the master clock value, a running block number, two time-code words, the marker divisor, the session flags and the version. The channel header carries the channel number, the format code, the requested word count, the partial-word status, the channel flags and the trailing partial word. Samples that do not fit in the data area are dropped. The resulting overrun is reported in the channel header of the following block. The configuration inputs are expected to come from registers and to stay stable while a block is being emitted.

Top module: `recblk_formatter`

## Requirements
- R1: Each block is exactly BLK_WORDS words (default 2048). `m_last` is high on the final word and on no other word. `m_valid` is low after reset and after the last word is accepted.
- R2: Word 0 is 0x36E19C. Word 1 holds 5'b01001 in bits 23:19 and `cfg_mclk` in bits 18:0.
- R3: Word 2 holds the block number. It is 0 after reset and after `sess_start` in the capture phase, and it rises by one after each completed block, modulo 2^24.
- R4: Words 3, 4 and 5 are `cfg_date`, `cfg_time` and `cfg_blkdiv`. Word 6 is {`cfg_mclk_int`, 4'b0 (one channel), 2'b0, `cfg_sst`}. Word 7 is {`cfg_user`, 10'b0, `cfg_ver`}. Words 10 and 11 are `cfg_ch_w2` and `cfg_ch_w3`.
- R5: The sample size for format code c is c+1 bits for c<8, and 2c-6 bits for c>=8 (10 to 24). Only the low bits of `s_data` are used. Samples are packed contiguously, MSB first, into the data words, which start at word 13.
- R6: Word 8 is {`cfg_chan`[23:20], `cfg_fmt`[19:16], word count[15:5], partial status[4:0]}. The word count is the number of full 24-bit words the offered samples need, saturating at 2040.
- R7: Let f be the number of bits in the partial word. The partial status is 0 when f is 0, and ceil((24-f)/size) otherwise.
- R8: Word 12 carries the bits left after the last full data word, left-aligned from bit 23 with the earliest bit first. Its low 24-f bits may be any value.
- R9: A sample that would need a data word beyond the BLK_WORDS-13 word data area is dropped, and so is every later sample in that block. The word count then exceeds the number of data words emitted. Bit 21 of word 9 in the next block reports the overrun, and `sess_start` clears it.
- R10: Word 9 is {`cfg_ch_int`, `cfg_ch_dig`, overrun, 1'b0, no-samples, `cfg_rate`}. The no-samples bit is 1 when no sample was stored in the block.
- R11: Every word after the last full data word up to the block end is 0xFFFFFF.
- R12: `s_ready` is high only in the capture phase and low throughout emission. While `m_valid` is high and `m_ready` is low, `m_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sess_start | input | 1 | Session start pulse, honoured in capture phase |
| blk_close | input | 1 | Ends capture and starts block emission |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample ready (capture phase) |
| s_data | input | 24 | Sample, right-aligned |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Output word accepted |
| m_data | output | 24 | Output word |
| m_last | output | 1 | Final word of the block |
| cfg_mclk | input | 19 | Master clock value |
| cfg_blkdiv | input | 24 | Block marker divisor |
| cfg_date | input | 24 | Date time code |
| cfg_time | input | 24 | Time-of-day time code |
| cfg_mclk_int | input | 1 | Master clock internal flag |
| cfg_sst | input | 17 | Session start second |
| cfg_user | input | 8 | User field |
| cfg_ver | input | 6 | Format version |
| cfg_chan | input | 4 | Physical channel number |
| cfg_fmt | input | 4 | Sample format code |
| cfg_ch_int | input | 1 | Channel clock internal flag |
| cfg_ch_dig | input | 1 | Digital channel flag |
| cfg_rate | input | 19 | Channel rate value |
| cfg_ch_w2 | input | 24 | Channel header word 2 contents |
| cfg_ch_w3 | input | 24 | Channel header word 3 contents |

## Verification
The assertions check on every cycle that output words are held under backpressure, that the word stream stops after its last word, and that the block number steps by one per completed block. They also check that the stored word count never passes the data-area capacity, that the store is frozen outside capture, and that the drop condition stays latched until the block ends. Only the bench scenarios can show the content of each word. These scenarios cover the size table across all sixteen format codes, the partial-word status arithmetic and the MSB-first packing across word boundaries. They also cover fill placement, the word count running past the emitted words on overflow, and the overrun and no-samples flags in the following block.

// File: rtl/recblk_pkg.sv
package recblk_pkg;
   localparam int          WORD_W     = 24;
   localparam logic [23:0] SYNC_LOW   = 24'h36E19C;
   localparam logic [4:0]  SYNC_HIGH  = 5'b01001;
   localparam int          SESS_WORDS = 8;
   localparam int          CHDR_WORDS = 5;
   localparam int          DATA_BASE  = SESS_WORDS + CHDR_WORDS;
   localparam int          WC_LIMIT   = 2040;

   typedef enum logic {PH_CAPTURE, PH_EMIT} phase_t;

   // sample width in bits for a format code: linear to 8, then steps of two
   function automatic logic [4:0] code_bits(input logic [3:0] code);
      if (!code[3]) return {2'b00, code[2:0]} + 5'd1;
      else          return {code[2:0], 1'b0} + 5'd10;
   endfunction
endpackage

// File: rtl/recblk_packer.sv
module recblk_packer
   import recblk_pkg::*;
#(
   parameter  int CAP_WORDS = 2035,
   localparam int AW        = $clog2(CAP_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              take,
   input  logic [3:0]        code,
   input  logic [23:0]       sample,
   input  logic [AW-1:0]     rd_idx,
   output logic [23:0]       rd_word,
   output logic [AW-1:0]     full_cnt,
   output logic [4:0]        part_bits,
   output logic [23:0]       part_word,
   output logic [10:0]       req_words,
   output logic              dropped,
   output logic              any_kept
);
   logic [23:0] store [CAP_WORDS];
   logic [4:0]  req_bits;
   logic [4:0]  sz;
   logic [24:0] mask25;
   logic [23:0] smp;
   logic [47:0] aligned, merged;
   logic [5:0]  sum, req_sum;
   logic        fits;

   always_comb begin
      sz      = code_bits(code);
      mask25  = (25'd1 << sz) - 25'd1;
      smp     = sample & mask25[23:0];
      aligned = ({smp, 24'd0} << (6'd24 - {1'b0, sz})) >> part_bits;
      merged  = {part_word, 24'd0} | aligned;
      sum     = {1'b0, part_bits} + {1'b0, sz};
      req_sum = {1'b0, req_bits} + {1'b0, sz};
      fits    = !dropped && ((full_cnt < AW'(CAP_WORDS)) || (sum < 6'd24));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_cnt  <= '0;
         part_bits <= '0;
         part_word <= '0;
         req_bits  <= '0;
         req_words <= '0;
         dropped   <= 1'b0;
         any_kept  <= 1'b0;
      end else if (clr) begin
         full_cnt  <= '0;
         part_bits <= '0;
         part_word <= '0;
         req_bits  <= '0;
         req_words <= '0;
         dropped   <= 1'b0;
         any_kept  <= 1'b0;
      end else if (take) begin
         if (req_sum >= 6'd24) begin
            req_bits <= 5'(req_sum - 6'd24);
            if (req_words != 11'(WC_LIMIT)) req_words <= req_words + 11'd1;
         end else begin
            req_bits <= req_sum[4:0];
         end
         if (fits) begin
            any_kept <= 1'b1;
            if (sum >= 6'd24) begin
               part_word <= merged[23:0];
               part_bits <= 5'(sum - 6'd24);
               full_cnt  <= full_cnt + AW'(1);
            end else begin
               part_word <= merged[47:24];
               part_bits <= sum[4:0];
            end
         end else begin
            dropped <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (take && !clr && fits && (sum >= 6'd24)) store[full_cnt] <= merged[47:24];
   end

   assign rd_word = (rd_idx < AW'(CAP_WORDS)) ? store[rd_idx] : '0;

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_cnt <= AW'(CAP_WORDS));
   // R9
   drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dropped && !clr) |=> dropped);
   // R12
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !clr) |=> ($stable(full_cnt) && $stable(part_word)));
endmodule

// File: rtl/recblk_sequencer.sv
module recblk_sequencer
   import recblk_pkg::*;
#(
   parameter  int BLK_WORDS = 2048,
   localparam int IW        = $clog2(BLK_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          close,
   input  logic          m_ready,
   output logic          capturing,
   output logic          m_valid,
   output logic          m_last,
   output logic [IW-1:0] idx,
   output logic          done
);
   phase_t phase;

   assign capturing = (phase == PH_CAPTURE);
   assign m_valid   = (phase == PH_EMIT);
   assign m_last    = m_valid && (idx == IW'(BLK_WORDS - 1));
   assign done      = m_last && m_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_CAPTURE;
         idx   <= '0;
      end else if (phase == PH_CAPTURE) begin
         idx <= '0;
         if (close) phase <= PH_EMIT;
      end else if (m_ready) begin
         if (m_last) phase <= PH_CAPTURE;
         else        idx   <= idx + IW'(1);
      end
   end

   // R1
   stop_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && m_ready && m_last) |=> !m_valid);
endmodule

// File: rtl/recblk_wordmux.sv
module recblk_wordmux
   import recblk_pkg::*;
#(
   parameter  int BLK_WORDS = 2048,
   parameter  int CAP_WORDS = 2035,
   localparam int IW        = $clog2(BLK_WORDS),
   localparam int AW        = $clog2(CAP_WORDS + 1)
) (
   input  logic [IW-1:0] idx,
   input  logic [23:0]   blk_num,
   input  logic          rovr,
   input  logic [AW-1:0] full_cnt,
   input  logic [4:0]    part_bits,
   input  logic [23:0]   part_word,
   input  logic [10:0]   req_words,
   input  logic          any_kept,
   input  logic [23:0]   rd_word,
   output logic [AW-1:0] rd_idx,
   input  logic [18:0]   cfg_mclk,
   input  logic [23:0]   cfg_blkdiv,
   input  logic [23:0]   cfg_date,
   input  logic [23:0]   cfg_time,
   input  logic          cfg_mclk_int,
   input  logic [16:0]   cfg_sst,
   input  logic [7:0]    cfg_user,
   input  logic [5:0]    cfg_ver,
   input  logic [3:0]    cfg_chan,
   input  logic [3:0]    cfg_fmt,
   input  logic          cfg_ch_int,
   input  logic          cfg_ch_dig,
   input  logic [18:0]   cfg_rate,
   input  logic [23:0]   cfg_ch_w2,
   input  logic [23:0]   cfg_ch_w3,
   output logic [23:0]   word
);
   logic [5:0]    unused, sz6, pws6;
   logic [4:0]    pws;
   logic [IW-1:0] off;
   int unsigned   iv, fc;

   always_comb begin
      sz6    = {1'b0, code_bits(cfg_fmt)};
      unused = 6'd24 - {1'b0, part_bits};
      pws6   = (unused + sz6 - 6'd1) / sz6;
      pws    = (part_bits == 5'd0) ? 5'd0 : pws6[4:0];
      off    = idx - IW'(DATA_BASE);
      rd_idx = AW'(off);
      iv     = int'(idx);
      fc     = int'(full_cnt);
      word   = '1;
      case (iv)
         0:  word = SYNC_LOW;
         1:  word = {SYNC_HIGH, cfg_mclk};
         2:  word = blk_num;
         3:  word = cfg_date;
         4:  word = cfg_time;
         5:  word = cfg_blkdiv;
         6:  word = {cfg_mclk_int, 4'd0, 2'd0, cfg_sst};
         7:  word = {cfg_user, 10'd0, cfg_ver};
         8:  word = {cfg_chan, cfg_fmt, req_words, pws};
         9:  word = {cfg_ch_int, cfg_ch_dig, rovr, 1'b0, !any_kept, cfg_rate};
         10: word = cfg_ch_w2;
         11: word = cfg_ch_w3;
         12: word = part_word;
         default: if (iv < DATA_BASE + fc) word = rd_word;
      endcase
   end
endmodule

// File: rtl/recblk_formatter.sv
module recblk_formatter
   import recblk_pkg::*;
#(
   parameter int BLK_WORDS = 2048
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sess_start,
   input  logic        blk_close,
   input  logic        s_valid,
   output logic        s_ready,
   input  logic [23:0] s_data,
   output logic        m_valid,
   input  logic        m_ready,
   output logic [23:0] m_data,
   output logic        m_last,
   input  logic [18:0] cfg_mclk,
   input  logic [23:0] cfg_blkdiv,
   input  logic [23:0] cfg_date,
   input  logic [23:0] cfg_time,
   input  logic        cfg_mclk_int,
   input  logic [16:0] cfg_sst,
   input  logic [7:0]  cfg_user,
   input  logic [5:0]  cfg_ver,
   input  logic [3:0]  cfg_chan,
   input  logic [3:0]  cfg_fmt,
   input  logic        cfg_ch_int,
   input  logic        cfg_ch_dig,
   input  logic [18:0] cfg_rate,
   input  logic [23:0] cfg_ch_w2,
   input  logic [23:0] cfg_ch_w3
);
   localparam int CAP_WORDS = BLK_WORDS - DATA_BASE;
   localparam int IW        = $clog2(BLK_WORDS);
   localparam int AW        = $clog2(CAP_WORDS + 1);

   generate
      if (BLK_WORDS <= DATA_BASE + 1) begin : g_bad_len
         $error("BLK_WORDS must leave room for data after both headers");
      end
      if (CAP_WORDS > WC_LIMIT) begin : g_bad_cap
         $error("data area exceeds the word-count field range");
      end
   endgenerate

   logic          capturing, done, sess_go, take, clr;
   logic [IW-1:0] idx;
   logic [23:0]   blk_num;
   logic          rovr;
   logic [AW-1:0] full_cnt, rd_idx;
   logic [4:0]    part_bits;
   logic [23:0]   part_word, rd_word;
   logic [10:0]   req_words;
   logic          dropped, any_kept;

   assign s_ready = capturing;
   assign take    = s_valid && capturing;
   assign sess_go = sess_start && capturing;
   assign clr     = done || sess_go;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_num <= '0;
         rovr    <= 1'b0;
      end else if (sess_go) begin
         blk_num <= '0;
         rovr    <= 1'b0;
      end else if (done) begin
         blk_num <= blk_num + 24'd1;
         rovr    <= dropped;
      end
   end

   recblk_sequencer #(.BLK_WORDS(BLK_WORDS)) u_seq (
      .clk(clk), .rst_n(rst_n), .close(blk_close), .m_ready(m_ready),
      .capturing(capturing), .m_valid(m_valid), .m_last(m_last),
      .idx(idx), .done(done));

   recblk_packer #(.CAP_WORDS(CAP_WORDS)) u_pack (
      .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .code(cfg_fmt),
      .sample(s_data), .rd_idx(rd_idx), .rd_word(rd_word),
      .full_cnt(full_cnt), .part_bits(part_bits), .part_word(part_word),
      .req_words(req_words), .dropped(dropped), .any_kept(any_kept));

   recblk_wordmux #(.BLK_WORDS(BLK_WORDS), .CAP_WORDS(CAP_WORDS)) u_mux (
      .idx(idx), .blk_num(blk_num), .rovr(rovr), .full_cnt(full_cnt),
      .part_bits(part_bits), .part_word(part_word), .req_words(req_words),
      .any_kept(any_kept), .rd_word(rd_word), .rd_idx(rd_idx),
      .cfg_mclk(cfg_mclk), .cfg_blkdiv(cfg_blkdiv), .cfg_date(cfg_date),
      .cfg_time(cfg_time), .cfg_mclk_int(cfg_mclk_int), .cfg_sst(cfg_sst),
      .cfg_user(cfg_user), .cfg_ver(cfg_ver), .cfg_chan(cfg_chan),
      .cfg_fmt(cfg_fmt), .cfg_ch_int(cfg_ch_int), .cfg_ch_dig(cfg_ch_dig),
      .cfg_rate(cfg_rate), .cfg_ch_w2(cfg_ch_w2), .cfg_ch_w3(cfg_ch_w3),
      .word(m_data));

   // R12
   hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
   // R3
   blknum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (blk_num == $past(blk_num) + 24'd1));
endmodule

// File: tb/recblk_formatter_test.sv
module recblk_formatter_test;
   localparam int BLK = 40;
   localparam int CAP = BLK - 13;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n, sess_start, blk_close, s_valid, s_ready, m_valid, m_ready, m_last;
   logic [23:0] s_data, m_data;
   logic [18:0] cfg_mclk = 19'h5A3C1;
   logic [23:0] cfg_blkdiv = 24'h00C350, cfg_date = 24'h250614, cfg_time = 24'h134502;
   logic        cfg_mclk_int = 1'b1;
   logic [16:0] cfg_sst = 17'h1A2B3;
   logic [7:0]  cfg_user = 8'hC5;
   logic [5:0]  cfg_ver = 6'd9;
   logic [3:0]  cfg_chan = 4'd6, cfg_fmt = 4'd0;
   logic        cfg_ch_int = 1'b0, cfg_ch_dig = 1'b1;
   logic [18:0] cfg_rate = 19'h2F00D;
   logic [23:0] cfg_ch_w2 = 24'hA1B2C3, cfg_ch_w3 = 24'h0F1E2D;

   recblk_formatter #(.BLK_WORDS(BLK)) uut (
      .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .blk_close(blk_close),
      .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
      .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
      .cfg_mclk(cfg_mclk), .cfg_blkdiv(cfg_blkdiv), .cfg_date(cfg_date),
      .cfg_time(cfg_time), .cfg_mclk_int(cfg_mclk_int), .cfg_sst(cfg_sst),
      .cfg_user(cfg_user), .cfg_ver(cfg_ver), .cfg_chan(cfg_chan),
      .cfg_fmt(cfg_fmt), .cfg_ch_int(cfg_ch_int), .cfg_ch_dig(cfg_ch_dig),
      .cfg_rate(cfg_rate), .cfg_ch_w2(cfg_ch_w2), .cfg_ch_w3(cfg_ch_w3));

   int  checks = 0, errors = 0, stall = 0;
   int  exp_blk = 0;
   bit  exp_rovr = 1'b0;
   bit  finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [23:0] sval(int c, int i);
      return 24'(i * 32'h9E3779 + c * 32'h1357 + 32'h2A);
   endfunction

   task automatic pulse_session();
      @(negedge clk) sess_start = 1'b1;
      @(negedge clk) sess_start = 1'b0;
      exp_blk  = 0;
      exp_rovr = 1'b0;
   endtask

   task automatic run_block(int c, int n);
      int S, sp, op, full, fillb, wc, pws, k;
      bit ovf;
      bit sb [0:CAP*24+23];
      logic [23:0] got [0:BLK-1];
      logic [23:0] ew, mask, v;
      S  = (c < 8) ? c + 1 : 2 * c - 6;
      sp = 0; op = 0; ovf = 1'b0;
      cfg_fmt = 4'(c);
      cfg_chan = 4'(c ^ 5);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         s_valid = 1'b1;
         s_data  = sval(c, i);
         v = sval(c, i);
         if (!ovf && ((sp / 24 < CAP) || ((sp % 24) + S < 24))) begin
            for (int b = S - 1; b >= 0; b--) begin
               sb[sp] = v[b];
               sp++;
            end
         end else ovf = 1'b1;
         op += S;
      end
      @(negedge clk) s_valid = 1'b0; blk_close = 1'b1;
      @(negedge clk) blk_close = 1'b0;
      k = 0;
      while (k < BLK) begin
         @(negedge clk);
         m_ready = (stall % 3) != 0;
         stall++;
         if (m_valid && m_ready) begin
            got[k] = m_data;
            if (k == 0) chk(s_ready == 1'b0, "R12 s_ready low while emitting", 32'(s_ready), 0);
            if (k == BLK - 1 || k == 5) chk(m_last == (k == BLK - 1), "R1 last flag", 32'(m_last), 32'(k == BLK - 1));
            k++;
         end
      end
      @(negedge clk) m_ready = 1'b0;
      chk(m_valid == 1'b0 && s_ready == 1'b1, "R1 stream ends after block", 32'(m_valid), 0);

      full  = sp / 24;
      fillb = sp % 24;
      wc    = (op / 24 > 2040) ? 2040 : op / 24;
      pws   = (fillb == 0) ? 0 : (24 - fillb + S - 1) / S;
      chk(got[0] == 24'h36E19C, "R2 sync low word", got[0], 24'h36E19C);
      chk(got[1] == {5'b01001, cfg_mclk}, "R2 sync high and mclk", got[1], {5'b01001, cfg_mclk});
      chk(got[2] == 24'(exp_blk), "R3 block number", got[2], exp_blk);
      chk(got[3] == cfg_date && got[4] == cfg_time && got[5] == cfg_blkdiv, "R4 time and divisor words", got[3], cfg_date);
      chk(got[6] == {cfg_mclk_int, 6'd0, cfg_sst}, "R4 flags word", got[6], {cfg_mclk_int, 6'd0, cfg_sst});
      chk(got[7] == {cfg_user, 10'd0, cfg_ver}, "R4 version word", got[7], {cfg_user, 10'd0, cfg_ver});
      chk(got[10] == cfg_ch_w2 && got[11] == cfg_ch_w3, "R4 channel words 2 and 3", got[10], cfg_ch_w2);
      chk(got[8][23:16] == {cfg_chan, cfg_fmt}, "R6 channel and format", got[8][23:16], {cfg_chan, cfg_fmt});
      chk(got[8][15:5] == 11'(wc), "R6 word count", got[8][15:5], wc);
      chk(got[8][4:0] == 5'(pws), "R7 partial status", got[8][4:0], pws);
      ew = {cfg_ch_int, cfg_ch_dig, exp_rovr, 1'b0, (sp == 0), cfg_rate};
      chk(got[9][21] == exp_rovr, "R9 overrun flag from previous block", got[9][21], exp_rovr);
      chk(got[9][19] == (sp == 0), "R10 no-samples flag", got[9][19], (sp == 0));
      chk(got[9] == ew, "R10 channel word 1", got[9], ew);
      if (ovf) chk(wc > full && int'(got[8][15:5]) > full, "R9 word count exceeds emitted words", got[8][15:5], full);
      ew = '0;
      for (int b = 0; b < 24; b++) ew[23 - b] = (b < fillb) ? sb[full * 24 + b] : 1'b0;
      mask = (fillb == 0) ? 24'd0 : ~(24'hFFFFFF >> fillb);
      chk((got[12] & mask) == ew, "R8 partial word", got[12] & mask, ew);
      for (int w = 13; w < BLK; w++) begin
         if (w < 13 + full) begin
            for (int b = 0; b < 24; b++) ew[23 - b] = sb[(w - 13) * 24 + b];
            chk(got[w] == ew, "R5 packed data word", got[w], ew);
         end else begin
            chk(got[w] == 24'hFFFFFF, "R11 fill word", got[w], 24'hFFFFFF);
         end
      end
      exp_blk++;
      exp_rovr = ovf;
   endtask

   initial begin
      rst_n = 1'b0; sess_start = 1'b0; blk_close = 1'b0;
      s_valid = 1'b0; s_data = '0; m_ready = 1'b0;
      repeat (3) @(negedge clk);
      chk(m_valid == 1'b0, "R1 no output after reset", 32'(m_valid), 0);
      chk(s_ready == 1'b1, "R12 capture after reset", 32'(s_ready), 1);
      rst_n = 1'b1;
      pulse_session();
      for (int c = 0; c < 16; c++) begin
         int S;
         S = (c < 8) ? c + 1 : 2 * c - 6;
         run_block(c, 5 + 2 * c);
         run_block(c, CAP * 24 / S + 5);
         run_block(c, 0);
      end
      run_block(3, 400);
      pulse_session();
      run_block(3, 10);
      run_block(15, 7);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule